// File: doc/BRIEF.md
# Control/Bulk List Service Arbiter

This block decides, one endpoint at a time, which endpoint list a host controller's list walker serves next inside a frame. A start-of-frame strobe opens each frame. The periodic list is served first. When that phase ends, the control and bulk lists share the rest of the frame in a weighted interleave. The weight comes from a 2-bit ratio input, which sets how many nonempty control endpoints are served for each bulk endpoint.

The walker reports, for each list, whether an endpoint is waiting. For the periodic list it also reports whether the waiting endpoint is isochronous. The arbiter answers with a one-hot grant and keeps it until the walker pulses done. The per-list enables are copied into shadow registers on the start-of-frame strobe, so a change to an enable input takes effect at the next frame boundary. The count of control endpoints served is kept across frame boundaries.

Descriptor fetching, memory traffic and transaction execution are outside this block.

Top module: `list_svc_arbiter`

## Requirements
- R1: After reset, `grant` is 0 and `phase` is 0 (idle). Until the first `sof` pulse no grant is issued, whatever the availability inputs show.
- R2: A `sof` pulse sets `phase` to 1 (periodic) at the clock edge that samples it. `phase` encoding: 0 idle, 1 periodic, 2 nonperiodic.
- R3: The four enables (periodic, isochronous, control, bulk) are sampled only on `sof`. A change to an enable input between strobes has no effect on grants until the next `sof`.
- R4: In the periodic phase, with the sampled periodic enable set and `per_avail` high, the arbiter grants periodic (`grant` bit 0). When the periodic enable is clear or `per_avail` is low, the phase moves to 2 without a grant.
- R5: In the periodic phase, a waiting endpoint flagged `per_is_iso` while the sampled isochronous enable is clear ends the periodic phase, and the phase moves to 2. Setting the isochronous enable takes effect only from the next frame.
- R6: In the nonperiodic phase, with both lists available, the arbiter serves ratio+1 control endpoints (`grant` bit 1) and then one bulk endpoint (`grant` bit 2). Ratio codes 0, 1, 2 and 3 give 1, 2, 3 and 4 control endpoints per bulk endpoint.
- R7: An empty or disabled control list lets bulk be granted at once. An empty or disabled bulk list lets control go on. The control count saturates at 4, so bulk wins as soon as it becomes available.
- R8: The count of control endpoints served is not cleared by `sof`. It carries into the next frame.
- R9: Completing a bulk endpoint clears the control count to zero.
- R10: `grant` is one-hot or zero. A grant is held unchanged until `done`. A `done` pulse while no grant is active is ignored.
- R11: A grant appears one clock edge after the decision point: the edge after `sof`, or the edge after the `done` that closed the previous grant.
- R12: A `sof` pulse withdraws any outstanding grant at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame strobe, one cycle |
| en_per | input | 1 | Periodic list enable (sampled at sof) |
| en_iso | input | 1 | Isochronous endpoint enable (sampled at sof) |
| en_ctrl | input | 1 | Control list enable (sampled at sof) |
| en_bulk | input | 1 | Bulk list enable (sampled at sof) |
| ratio | input | 2 | Control-per-bulk weight, serves ratio+1 control endpoints |
| per_avail | input | 1 | A periodic endpoint is waiting |
| per_is_iso | input | 1 | The waiting periodic endpoint is isochronous |
| ctrl_avail | input | 1 | A nonempty control endpoint is waiting |
| bulk_avail | input | 1 | A nonempty bulk endpoint is waiting |
| done | input | 1 | Walker finished the granted endpoint (handshake with grant) |
| grant | output | 3 | One-hot grant: bit0 periodic, bit1 control, bit2 bulk |
| phase | output | 2 | Frame phase: 0 idle, 1 periodic, 2 nonperiodic |

## Verification
A wrong control count changes the order of grants. With both lists busy, the first bulk grant arrives one service earlier or later than the ratio allows, which shows within ratio+2 grants. The carry-over checks cross a frame boundary in the middle of a run to bring out a count that was cleared when it should have been kept. A stale or too-eager shadow enable shows as a grant to a list whose input enable was changed in the middle of the frame, at the very next decision. Phase errors show on `phase` one edge after `sof`, or as a periodic grant after an isochronous stop.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_PER    = 2'd1,
    PH_NONPER = 2'd2
  } phase_e;

  localparam int GNT_W    = 3;
  localparam int GNT_PER  = 0;
  localparam int GNT_CTRL = 1;
  localparam int GNT_BULK = 2;

  typedef struct packed {
    logic per;
    logic iso;
    logic ctrl;
    logic bulk;
  } list_en_t;
endpackage

// File: rtl/lsa_shadow.sv
module lsa_shadow
  import lsa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sof,
  input  list_en_t en_in,
  output list_en_t en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= '0;
    else if (sof) en_q <= en_in;
  end

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(en_q)); // R3
endmodule

// File: rtl/lsa_weight.sv
module lsa_weight #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ctrl_ok,
  input  logic               bulk_ok,
  input  logic               done_ctrl,
  input  logic               done_bulk,
  output logic               pick_ctrl,
  output logic               pick_bulk
);
  localparam int CNT_W = RATIO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << RATIO_W);

  logic [CNT_W-1:0] ctrl_cnt;
  logic [CNT_W-1:0] thresh;
  logic             under;

  assign thresh    = {1'b0, ratio} + CNT_W'(1);
  assign under     = ctrl_cnt < thresh;
  assign pick_ctrl = ctrl_ok && (under || !bulk_ok);
  assign pick_bulk = bulk_ok && !pick_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ctrl_cnt <= '0;
    else if (done_bulk)                       ctrl_cnt <= '0;
    else if (done_ctrl && ctrl_cnt < CNT_MAX) ctrl_cnt <= ctrl_cnt + CNT_W'(1);
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_cnt <= CNT_MAX); // R7
  AST_BULK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_bulk |=> ctrl_cnt == '0); // R9
  AST_CTRL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ctrl && !done_bulk && ctrl_cnt < CNT_MAX) |=> ctrl_cnt == $past(ctrl_cnt) + CNT_W'(1)); // R6
  AST_PICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pick_ctrl && pick_bulk)); // R10
endmodule

// File: rtl/lsa_phase.sv
module lsa_phase
  import lsa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             done,
  input  list_en_t         en_q,
  input  logic             per_avail,
  input  logic             per_is_iso,
  input  logic             pick_ctrl,
  input  logic             pick_bulk,
  output phase_e           phase,
  output logic [GNT_W-1:0] grant,
  output logic             done_ctrl,
  output logic             done_bulk
);
  logic per_stop;

  assign per_stop  = !en_q.per || !per_avail || (per_is_iso && !en_q.iso);
  assign done_ctrl = done && grant[GNT_CTRL];
  assign done_bulk = done && grant[GNT_BULK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      grant <= '0;
    end else if (sof) begin
      phase <= PH_PER;
      grant <= '0;
    end else if (grant != '0) begin
      if (done) grant <= '0;
    end else begin
      unique case (phase)
        PH_PER: begin
          if (per_stop) phase <= PH_NONPER;
          else          grant <= GNT_W'(1 << GNT_PER);
        end
        PH_NONPER: begin
          if (pick_ctrl)      grant <= GNT_W'(1 << GNT_CTRL);
          else if (pick_bulk) grant <= GNT_W'(1 << GNT_BULK);
        end
        default: ;
      endcase
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done && !sof) |=> $stable(grant)); // R10
  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (grant == '0 && phase == PH_PER)); // R12
  AST_PER_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    grant[GNT_PER] |-> phase == PH_PER); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IDLE |-> grant == '0); // R1
endmodule

// File: rtl/list_svc_arbiter.sv
module list_svc_arbiter
  import lsa_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof,
  input  logic               en_per,
  input  logic               en_iso,
  input  logic               en_ctrl,
  input  logic               en_bulk,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               per_avail,
  input  logic               per_is_iso,
  input  logic               ctrl_avail,
  input  logic               bulk_avail,
  input  logic               done,
  output logic [GNT_W-1:0]   grant,
  output logic [1:0]         phase
);
  list_en_t en_in, en_q;
  logic     pick_ctrl, pick_bulk, done_ctrl, done_bulk;
  phase_e   ph;

  assign en_in = '{per: en_per, iso: en_iso, ctrl: en_ctrl, bulk: en_bulk};
  assign phase = ph;

  lsa_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .sof(sof), .en_in(en_in), .en_q(en_q)
  );

  lsa_weight #(.RATIO_W(RATIO_W)) u_weight (
    .clk(clk), .rst_n(rst_n), .ratio(ratio),
    .ctrl_ok(en_q.ctrl && ctrl_avail), .bulk_ok(en_q.bulk && bulk_avail),
    .done_ctrl(done_ctrl), .done_bulk(done_bulk),
    .pick_ctrl(pick_ctrl), .pick_bulk(pick_bulk)
  );

  lsa_phase u_phase (
    .clk(clk), .rst_n(rst_n), .sof(sof), .done(done), .en_q(en_q),
    .per_avail(per_avail), .per_is_iso(per_is_iso),
    .pick_ctrl(pick_ctrl), .pick_bulk(pick_bulk),
    .phase(ph), .grant(grant), .done_ctrl(done_ctrl), .done_bulk(done_bulk)
  );

  AST_CTRL_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant[GNT_CTRL]) |-> $past(en_q.ctrl)); // R3
  AST_BULK_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant[GNT_BULK]) |-> $past(en_q.bulk)); // R3
endmodule

// File: tb/list_svc_arbiter_test.sv
module list_svc_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 0, en_per = 0, en_iso = 0, en_ctrl = 0, en_bulk = 0;
  logic [1:0] ratio = 2'd0;
  logic per_avail = 0, per_is_iso = 0, ctrl_avail = 0, bulk_avail = 0, done = 0;
  logic [2:0] grant;
  logic [1:0] phase;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  localparam logic [2:0] G_P = 3'b001, G_C = 3'b010, G_B = 3'b100, G_0 = 3'b000;

  always #10 clk = ~clk;

  list_svc_arbiter uut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .en_per(en_per), .en_iso(en_iso),
    .en_ctrl(en_ctrl), .en_bulk(en_bulk), .ratio(ratio), .per_avail(per_avail),
    .per_is_iso(per_is_iso), .ctrl_avail(ctrl_avail), .bulk_avail(bulk_avail),
    .done(done), .grant(grant), .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sof();
    sof = 1'b1; step(1); sof = 1'b0;
  endtask

  task automatic serve(input logic [2:0] exp, input string req);
    for (int i = 0; i < 6; i++) begin
      if (grant != G_0) break;
      step(1);
    end
    chk(req, grant, exp);
    done = 1'b1; step(1); done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 grant", grant, 0);
    chk("R1 phase", phase, 0);
    en_ctrl = 1; en_per = 1; ctrl_avail = 1; per_avail = 1;
    step(4);
    chk("R1 no grant before sof", grant, 0);
    en_per = 0; per_avail = 0;
  endtask

  task automatic t_ratio();
    en_ctrl = 1; en_bulk = 1; ctrl_avail = 1; bulk_avail = 1; ratio = 2'd1;
    pulse_sof();
    chk("R2 phase after sof", phase, 1);
    chk("R11 no grant on sof edge", grant, 0);
    serve(G_C, "R6 2:1 c1"); serve(G_C, "R6 2:1 c2"); serve(G_B, "R6 2:1 b");
    serve(G_C, "R6 2:1 c3"); serve(G_C, "R6 2:1 c4"); serve(G_B, "R6 2:1 b2");
    ratio = 2'd0;
    serve(G_C, "R6 1:1 c"); serve(G_B, "R6 1:1 b");
    ratio = 2'd3;
    for (int k = 0; k < 4; k++) serve(G_C, "R6 4:1 c");
    serve(G_B, "R6 4:1 b");
  endtask

  task automatic t_carry();
    ratio = 2'd2;
    pulse_sof();
    serve(G_C, "R8 c1"); serve(G_C, "R8 c2");
    pulse_sof();
    serve(G_C, "R8 c3 after sof"); serve(G_B, "R8 b after carry");
    serve(G_C, "R9 c after bulk clear");
    serve(G_C, "R9 c2"); serve(G_C, "R9 c3"); serve(G_B, "R9 b");
  endtask

  task automatic t_empty();
    ctrl_avail = 0;
    serve(G_B, "R7 empty ctrl b1"); serve(G_B, "R7 empty ctrl b2");
    ctrl_avail = 1; bulk_avail = 0;
    for (int k = 0; k < 6; k++) serve(G_C, "R7 empty bulk c");
    bulk_avail = 1;
    serve(G_B, "R7 saturated count gives bulk");
  endtask

  task automatic t_periodic();
    en_per = 1; en_iso = 0; per_avail = 1; per_is_iso = 0;
    bulk_avail = 0; ratio = 2'd2;
    pulse_sof();
    step(1);
    chk("R11 periodic grant one edge after sof", grant, G_P);
    done = 1'b1; step(1); done = 1'b0;
    serve(G_P, "R4 periodic again");
    chk("R4 still periodic phase", phase, 1);
    per_is_iso = 1;
    step(1);
    chk("R5 iso stop phase", phase, 2);
    chk("R5 iso stop no grant", grant, 0);
    en_iso = 1;
    serve(G_C, "R5 iso enable waits for next frame");
    pulse_sof();
    serve(G_P, "R5 iso allowed next frame");
    per_avail = 0;
    serve(G_C, "R4 list end moves to nonperiodic");
    chk("R4 phase nonperiodic", phase, 2);
    en_per = 0; en_iso = 0; per_is_iso = 0;
  endtask

  task automatic t_enables();
    en_ctrl = 1; en_bulk = 0; ctrl_avail = 1; bulk_avail = 1; ratio = 2'd0;
    pulse_sof();
    en_ctrl = 0; en_bulk = 1;
    serve(G_C, "R3 ctrl kept mid-frame"); serve(G_C, "R3 bulk not yet");
    pulse_sof();
    serve(G_B, "R3 new enables b1"); serve(G_B, "R3 new enables b2");
  endtask

  task automatic t_hold();
    en_ctrl = 1; en_bulk = 1; bulk_avail = 0;
    pulse_sof();
    step(2);
    chk("R10 grant issued", grant, G_C);
    step(5);
    chk("R10 grant held", grant, G_C);
    pulse_sof();
    chk("R12 sof withdraws", grant, 0);
    chk("R12 phase restarts", phase, 1);
    ctrl_avail = 0;
    step(2);
    chk("R10 nonper idle", phase, 2);
    done = 1'b1; step(1); done = 1'b0;
    chk("R10 stray done ignored", grant, 0);
    ctrl_avail = 1; bulk_avail = 1; ratio = 2'd0;
    serve(G_C, "R10 order after stray done");
    serve(G_B, "R10 order after stray done b");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_ratio();
    t_carry();
    t_empty();
    t_periodic();
    t_enables();
    t_hold();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule